// File: doc/BRIEF.md
# Stride-Filtered Markov Address Predictor

This block produces the next address for a stream buffer that prefetches data for one load instruction. It keeps a small table keyed by the load's program counter. Each entry holds the full PC as a tag, the most recent address the load touched, the last observed stride, and a 2-bit saturating confidence counter. Committed load addresses arrive on the training port. Each one updates its entry. When the new address does not continue the stored stride, the training port also records the jump from the previous address in a first-order Markov table.

The Markov table is direct-mapped. It is indexed by the address bits just above the cache-line offset and guarded by a partial tag. Each entry keeps only a signed 16-bit difference, not the full successor address, so the table stays small. Jumps that do not fit in 16 bits are dropped.

A stream buffer uses the block in two steps. When it is allocated, it copies the load's last address, stride and confidence through the lookup port. After that it asks for each next address through the predict port, presenting its own copy of that state. When confidence is 2 or more, the answer is the last address plus the stride. Otherwise the answer comes from the Markov table, or there is no prediction.

Top module: `sfm_predictor`

## Requirements
- R1: After reset every load-table and Markov entry is empty. A lookup returns `alloc_hit`=0, and a predict request with confidence below 2 returns `pred_valid`=1 with `pred_hit`=0. While reset is held, `alloc_valid` and `pred_valid` are 0.
- R2: A training update whose PC misses the load table (entry empty, or its stored full-PC tag differs) fills the entry selected by PC bits [PC_LSB +: log2(LT_DEPTH)]. The entry gets last address = the update address, stride = 0 and confidence = 0. The Markov table is not written. A lookup answers one cycle after `alloc_req` with `alloc_valid`=1 and the entry's contents.
- R3: A training update that hits its PC entry computes diff = address − last address, modulo 2^ADDR_W. If diff equals the stored stride, confidence goes up by one and saturates at 3. Otherwise the stride becomes diff and confidence drops to 0. In both cases the last address becomes the new address.
- R4: A predict request with confidence ≥ 2 answers one cycle later with `pred_valid`=1, `pred_hit`=1, `pred_from_stride`=1 and `pred_addr` = last + stride, modulo 2^ADDR_W.
- R5: A predict request with confidence < 2 looks up the Markov entry at index last[LINE_W +: log2(MK_DEPTH)]. If that entry is valid and its tag equals last[LINE_W+log2(MK_DEPTH) +: MTAG_W], the block answers one cycle later with `pred_hit`=1, `pred_from_stride`=0 and `pred_addr` = last + sign-extended stored delta.
- R6: A training update that hits its PC entry and breaks the stride writes a Markov entry. The key is the previous last address and the stored delta is diff.
- R7: A training update that continues the stored stride writes nothing to the Markov table.
- R8: A diff outside −32768..32767 is not written, and the Markov entry at that index keeps its old contents.
- R9: A Markov entry that is empty, or whose tag differs, gives `pred_hit`=0 and `pred_from_stride`=0 with `pred_valid`=1.
- R10: A Markov write replaces whatever occupied its index, including an entry with a different tag.
- R11: An update for a different PC that maps to the same load-table index evicts the old PC. A later lookup of the old PC misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_valid | input | 1 | Committed load training update |
| upd_pc | input | PC_W | PC of the committed load |
| upd_addr | input | ADDR_W | Address of the committed load |
| alloc_req | input | 1 | Lookup of a load's state at buffer allocation |
| alloc_pc | input | PC_W | PC to look up |
| alloc_valid | output | 1 | Lookup answer present (one cycle after request) |
| alloc_hit | output | 1 | PC found in load table |
| alloc_last | output | ADDR_W | Stored last address |
| alloc_stride | output | ADDR_W | Stored stride |
| alloc_conf | output | 2 | Stored confidence |
| pred_req | input | 1 | Next-address request from a stream buffer |
| pred_last | input | ADDR_W | Buffer's copy of the last address |
| pred_stride | input | ADDR_W | Buffer's copy of the stride |
| pred_conf | input | 2 | Buffer's copy of the confidence |
| pred_valid | output | 1 | Prediction answer present (one cycle after request) |
| pred_hit | output | 1 | A predicted address is supplied |
| pred_from_stride | output | 1 | Address came from the stride path |
| pred_addr | output | ADDR_W | Predicted next address |

## Verification
The stride path is swept over every confidence value against strides that are zero, small positive, negative, and large enough to wrap the address. This separates the threshold at 2 from an off-by-one threshold and shows that the addition wraps. Every Markov index is then filled from a fresh load with a delta that alternates in sign and includes both 16-bit extremes. This tests sign extension and indexing, and probing each key with its tag flipped shows that the partial tag really rejects. Steady strides raise confidence through to saturation while their successors stay absent from the Markov table. Out-of-range jumps aimed at an already filled index leave its old answer in place, which tells the range filter apart from an unconditional write.

// File: rtl/sfm_pkg.sv
// Shared types for the stride-filtered Markov predictor.
// Assumes confidence is always a 2-bit saturating count.
package sfm_pkg;
    typedef logic [1:0] conf_t;
    localparam conf_t CONF_MAX = 2'd3;

    // Saturating increment of a confidence value.
    function automatic conf_t conf_bump(input conf_t c);
        return (c == CONF_MAX) ? c : c + 2'd1;
    endfunction
endpackage

// File: rtl/sfm_load_table.sv
// Per-load state table: full-PC tag, last address, stride, confidence.
// Trains on committed loads. Emits a Markov write candidate when a hit
// breaks the stored stride. Answers allocation lookups one cycle later.
// Assumes at most one update and one lookup per cycle; a lookup sees
// contents from before a same-cycle update.
module sfm_load_table
    import sfm_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int ADDR_W   = 32,
    parameter int LT_DEPTH = 64,
    parameter int PC_LSB   = 2,
    parameter int KEY_LSB  = 6,
    parameter int KEY_W    = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              al_req,
    input  logic [PC_W-1:0]   al_pc,
    output logic              al_valid,
    output logic              al_hit,
    output logic [ADDR_W-1:0] al_last,
    output logic [ADDR_W-1:0] al_stride,
    output conf_t             al_conf,
    output logic              mk_cand,
    output logic [KEY_W-1:0]  mk_key,
    output logic [ADDR_W-1:0] mk_diff
);
    localparam int IDX_W = $clog2(LT_DEPTH);

    logic              lt_vld    [LT_DEPTH];
    logic [PC_W-1:0]   lt_tag    [LT_DEPTH];
    logic [ADDR_W-1:0] lt_last   [LT_DEPTH];
    logic [ADDR_W-1:0] lt_stride [LT_DEPTH];
    conf_t             lt_conf   [LT_DEPTH];

    logic [IDX_W-1:0]  u_idx, a_idx;
    logic              u_hit, u_match;
    logic [ADDR_W-1:0] u_diff, u_prev;

    // Decode the training update against its selected entry.
    always_comb begin
        u_idx   = upd_pc[PC_LSB +: IDX_W];
        a_idx   = al_pc[PC_LSB +: IDX_W];
        u_prev  = lt_last[u_idx];
        u_hit   = lt_vld[u_idx] && (lt_tag[u_idx] == upd_pc);
        u_diff  = upd_addr - u_prev;
        u_match = (u_diff == lt_stride[u_idx]);
    end

    // Offer a Markov insertion only for a hit that breaks the stride.
    always_comb begin
        mk_cand = upd_valid && u_hit && !u_match;
        mk_key  = u_prev[KEY_LSB +: KEY_W];
        mk_diff = u_diff;
    end

    // Valid bits: cleared on reset, set when an entry is filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LT_DEPTH; i++) lt_vld[i] <= 1'b0;
        end else if (upd_valid) begin
            lt_vld[u_idx] <= 1'b1;
        end
    end

    // Entry payload: allocate on miss, train stride and confidence on hit.
    always_ff @(posedge clk) begin
        if (upd_valid) begin
            lt_last[u_idx] <= upd_addr;
            if (!u_hit) begin
                lt_tag[u_idx]    <= upd_pc;
                lt_stride[u_idx] <= '0;
                lt_conf[u_idx]   <= '0;
            end else if (u_match) begin
                lt_conf[u_idx]   <= conf_bump(lt_conf[u_idx]);
            end else begin
                lt_stride[u_idx] <= u_diff;
                lt_conf[u_idx]   <= '0;
            end
        end
    end

    // Allocation lookup answer, registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            al_valid  <= 1'b0;
            al_hit    <= 1'b0;
            al_last   <= '0;
            al_stride <= '0;
            al_conf   <= '0;
        end else begin
            al_valid  <= al_req;
            al_hit    <= al_req && lt_vld[a_idx] && (lt_tag[a_idx] == al_pc);
            al_last   <= lt_last[a_idx];
            al_stride <= lt_stride[a_idx];
            al_conf   <= lt_conf[a_idx];
        end
    end

    // R3: a stride-continuing hit never lowers that entry's confidence.
    assert_conf_climb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && u_hit && u_match) |=> (lt_conf[$past(u_idx)] >= $past(lt_conf[u_idx])));

    // R2: a lookup answer appears exactly one cycle after its request.
    assert_lookup_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        al_req |=> al_valid);
endmodule

// File: rtl/sfm_markov_table.sv
// Direct-mapped first-order Markov table of signed address deltas.
// Writes are dropped when the difference does not fit DELTA_W bits.
// Read is combinational; the key is pre-sliced above the line offset.
module sfm_markov_table #(
    parameter int ADDR_W   = 32,
    parameter int MK_DEPTH = 2048,
    parameter int MTAG_W   = 8,
    parameter int DELTA_W  = 16,
    localparam int MIDX_W  = $clog2(MK_DEPTH),
    localparam int KEY_W   = MIDX_W + MTAG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_cand,
    input  logic [KEY_W-1:0]   wr_key,
    input  logic [ADDR_W-1:0]  wr_diff,
    input  logic [KEY_W-1:0]   rd_key,
    output logic               rd_hit,
    output logic [DELTA_W-1:0] rd_delta
);
    localparam int HI_W = ADDR_W - DELTA_W + 1;

    logic               mk_vld   [MK_DEPTH];
    logic [MTAG_W-1:0]  mk_tag   [MK_DEPTH];
    logic [DELTA_W-1:0] mk_delta [MK_DEPTH];

    logic [HI_W-1:0]   hi_bits;
    logic              fits, wr_en;
    logic [MIDX_W-1:0] w_idx, r_idx;
    logic [MTAG_W-1:0] w_tag, r_tag;

    // Range filter: upper bits must all match the delta's sign bit.
    always_comb begin
        hi_bits = wr_diff[ADDR_W-1 -: HI_W];
        fits    = (&hi_bits) || !(|hi_bits);
        wr_en   = wr_cand && fits;
        w_idx   = wr_key[MIDX_W-1:0];
        w_tag   = wr_key[KEY_W-1 -: MTAG_W];
        r_idx   = rd_key[MIDX_W-1:0];
        r_tag   = rd_key[KEY_W-1 -: MTAG_W];
    end

    // Valid bits: cleared on reset, set on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MK_DEPTH; i++) mk_vld[i] <= 1'b0;
        end else if (wr_en) begin
            mk_vld[w_idx] <= 1'b1;
        end
    end

    // Tag and delta storage, overwritten by any accepted write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mk_tag[w_idx]   <= w_tag;
            mk_delta[w_idx] <= wr_diff[DELTA_W-1:0];
        end
    end

    // Combinational lookup with partial-tag compare.
    always_comb begin
        rd_hit   = mk_vld[r_idx] && (mk_tag[r_idx] == r_tag);
        rd_delta = mk_delta[r_idx];
    end

    // R8: an accepted write leaves a valid entry at its index next cycle.
    assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cand && fits) |=> mk_vld[$past(w_idx)]);
endmodule

// File: rtl/sfm_next_addr.sv
// Chooses between the stride path and the Markov path for one request
// and registers the answer. Assumes Markov read data belongs to the
// same request address in the same cycle.
module sfm_next_addr
    import sfm_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DELTA_W  = 16,
    parameter int CONF_THR = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_last,
    input  logic [ADDR_W-1:0]  req_stride,
    input  conf_t              req_conf,
    input  logic               mk_hit,
    input  logic [DELTA_W-1:0] mk_delta,
    output logic               pr_valid,
    output logic               pr_hit,
    output logic               pr_from_stride,
    output logic [ADDR_W-1:0]  pr_addr
);
    logic              use_stride;
    logic [ADDR_W-1:0] delta_ext, next_addr;

    // Pick the source and form the candidate address.
    always_comb begin
        use_stride = (req_conf >= conf_t'(CONF_THR));
        delta_ext  = {{(ADDR_W-DELTA_W){mk_delta[DELTA_W-1]}}, mk_delta};
        next_addr  = use_stride ? (req_last + req_stride) : (req_last + delta_ext);
    end

    // Register the answer one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr_valid       <= 1'b0;
            pr_hit         <= 1'b0;
            pr_from_stride <= 1'b0;
            pr_addr        <= '0;
        end else begin
            pr_valid       <= req_valid;
            pr_hit         <= req_valid && (use_stride || mk_hit);
            pr_from_stride <= req_valid && use_stride;
            if (req_valid) pr_addr <= next_addr;
        end
    end

    // R4: a confident request yields the stride sum one cycle later.
    assert_stride_pick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_conf >= conf_t'(CONF_THR)) |=>
        (pr_valid && pr_hit && pr_from_stride && pr_addr == $past(req_last + req_stride)));

    // R5: a low-confidence request never reports the stride source.
    assert_markov_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_conf < conf_t'(CONF_THR)) |=> (pr_valid && !pr_from_stride));
endmodule

// File: rtl/sfm_predictor.sv
// Top of the stride-filtered Markov address predictor. Wires the per-load
// table, the delta table and the next-address selector together.
// Assumes LINE_W + log2(MK_DEPTH) + MTAG_W <= ADDR_W.
module sfm_predictor
    import sfm_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int PC_W     = 32,
    parameter int LT_DEPTH = 64,
    parameter int PC_LSB   = 2,
    parameter int MK_DEPTH = 2048,
    parameter int LINE_W   = 6,
    parameter int MTAG_W   = 8,
    parameter int DELTA_W  = 16,
    parameter int CONF_THR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              alloc_req,
    input  logic [PC_W-1:0]   alloc_pc,
    output logic              alloc_valid,
    output logic              alloc_hit,
    output logic [ADDR_W-1:0] alloc_last,
    output logic [ADDR_W-1:0] alloc_stride,
    output logic [1:0]        alloc_conf,
    input  logic              pred_req,
    input  logic [ADDR_W-1:0] pred_last,
    input  logic [ADDR_W-1:0] pred_stride,
    input  logic [1:0]        pred_conf,
    output logic              pred_valid,
    output logic              pred_hit,
    output logic              pred_from_stride,
    output logic [ADDR_W-1:0] pred_addr
);
    localparam int MIDX_W = $clog2(MK_DEPTH);
    localparam int KEY_W  = MIDX_W + MTAG_W;

    logic               mk_cand, mk_hit;
    logic [KEY_W-1:0]   mk_key, rd_key;
    logic [ADDR_W-1:0]  mk_diff;
    logic [DELTA_W-1:0] mk_delta;
    conf_t              al_conf_w;

    // Markov lookup key taken from the buffer's last address.
    always_comb rd_key = pred_last[LINE_W +: KEY_W];

    // Confidence output.
    always_comb alloc_conf = al_conf_w;

    sfm_load_table #(
        .PC_W(PC_W), .ADDR_W(ADDR_W), .LT_DEPTH(LT_DEPTH),
        .PC_LSB(PC_LSB), .KEY_LSB(LINE_W), .KEY_W(KEY_W)
    ) u_load (
        .clk(clk), .rst_n(rst_n),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_addr(upd_addr),
        .al_req(alloc_req), .al_pc(alloc_pc),
        .al_valid(alloc_valid), .al_hit(alloc_hit), .al_last(alloc_last),
        .al_stride(alloc_stride), .al_conf(al_conf_w),
        .mk_cand(mk_cand), .mk_key(mk_key), .mk_diff(mk_diff)
    );

    sfm_markov_table #(
        .ADDR_W(ADDR_W), .MK_DEPTH(MK_DEPTH), .MTAG_W(MTAG_W), .DELTA_W(DELTA_W)
    ) u_markov (
        .clk(clk), .rst_n(rst_n),
        .wr_cand(mk_cand), .wr_key(mk_key), .wr_diff(mk_diff),
        .rd_key(rd_key), .rd_hit(mk_hit), .rd_delta(mk_delta)
    );

    sfm_next_addr #(
        .ADDR_W(ADDR_W), .DELTA_W(DELTA_W), .CONF_THR(CONF_THR)
    ) u_next (
        .clk(clk), .rst_n(rst_n),
        .req_valid(pred_req), .req_last(pred_last), .req_stride(pred_stride),
        .req_conf(pred_conf), .mk_hit(mk_hit), .mk_delta(mk_delta),
        .pr_valid(pred_valid), .pr_hit(pred_hit),
        .pr_from_stride(pred_from_stride), .pr_addr(pred_addr)
    );

    // R9: no hit is reported without a valid answer.
    assert_hit_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid |-> !pred_hit);

    // R1: answers appear only in the cycle after a request.
    assert_answer_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> $past(pred_req));
endmodule

// File: tb/sfm_predictor_bench.sv
// Self-checking bench on a small configuration: 4 load entries, 16 Markov
// entries with 4-bit tags, 64-byte lines, 16-bit deltas.
module sfm_predictor_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0, upd_addr = '0;
    logic        alloc_req = 1'b0;
    logic [31:0] alloc_pc = '0;
    logic        alloc_valid, alloc_hit;
    logic [31:0] alloc_last, alloc_stride;
    logic [1:0]  alloc_conf;
    logic        pred_req = 1'b0;
    logic [31:0] pred_last = '0, pred_stride = '0;
    logic [1:0]  pred_conf = '0;
    logic        pred_valid, pred_hit, pred_from_stride;
    logic [31:0] pred_addr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfm_predictor #(
        .ADDR_W(32), .PC_W(32), .LT_DEPTH(4), .PC_LSB(2),
        .MK_DEPTH(16), .LINE_W(6), .MTAG_W(4), .DELTA_W(16), .CONF_THR(2)
    ) u_sfm_predictor (
        .clk(clk), .rst_n(rst_n),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_addr(upd_addr),
        .alloc_req(alloc_req), .alloc_pc(alloc_pc),
        .alloc_valid(alloc_valid), .alloc_hit(alloc_hit), .alloc_last(alloc_last),
        .alloc_stride(alloc_stride), .alloc_conf(alloc_conf),
        .pred_req(pred_req), .pred_last(pred_last), .pred_stride(pred_stride),
        .pred_conf(pred_conf), .pred_valid(pred_valid), .pred_hit(pred_hit),
        .pred_from_stride(pred_from_stride), .pred_addr(pred_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic train(input logic [31:0] pc, input logic [31:0] addr);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_addr = addr;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic lookup(input string req, input logic [31:0] pc, input logic hit,
                          input logic [31:0] last, input logic [31:0] stride,
                          input logic [1:0] conf);
        @(negedge clk);
        alloc_req = 1'b1; alloc_pc = pc;
        @(negedge clk);
        alloc_req = 1'b0;
        chk(req, {31'd0, alloc_valid}, 32'd1);
        chk(req, {31'd0, alloc_hit}, {31'd0, hit});
        if (hit) begin
            chk(req, alloc_last, last);
            chk(req, alloc_stride, stride);
            chk(req, {30'd0, alloc_conf}, {30'd0, conf});
        end
    endtask

    task automatic predict(input string req, input logic [31:0] last,
                           input logic [31:0] stride, input logic [1:0] conf,
                           input logic hit, input logic from_s, input logic [31:0] addr);
        @(negedge clk);
        pred_req = 1'b1; pred_last = last; pred_stride = stride; pred_conf = conf;
        @(negedge clk);
        pred_req = 1'b0;
        chk(req, {31'd0, pred_valid}, 32'd1);
        chk(req, {31'd0, pred_hit}, {31'd0, hit});
        chk(req, {31'd0, pred_from_stride}, {31'd0, from_s});
        if (hit) chk(req, pred_addr, addr);
    endtask

    function automatic int delta_of(input int i);
        if (i == 14) return 32767;
        if (i == 15) return -32768;
        if (i % 2 == 0) return i * 100 + 1;
        return -(i * 300 + 7);
    endfunction

    function automatic logic [31:0] key_of(input int i);
        return 32'h8000 + 32'(i * 64);
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] a;
        // R1: outputs quiet during reset
        repeat (3) @(negedge clk);
        chk("R1 reset alloc_valid", {31'd0, alloc_valid}, 32'd0);
        chk("R1 reset pred_valid", {31'd0, pred_valid}, 32'd0);
        rst_n = 1'b1;
        lookup("R1 empty load table", 32'h24, 1'b0, '0, '0, 2'd0);
        predict("R1 empty markov", 32'h1000, 32'd64, 2'd0, 1'b0, 1'b0, '0);

        // R4 sweep (Markov still empty, so conf<2 misses: R9)
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 5; s++) begin
                for (int l = 0; l < 3; l++) begin
                    logic [31:0] sv, lv;
                    sv = (s == 0) ? 32'd0 : (s == 1) ? 32'd64 : (s == 2) ? 32'hFFFF_FFC0 :
                         (s == 3) ? 32'h7FFF_FFFF : 32'd4;
                    lv = (l == 0) ? 32'h0 : (l == 1) ? 32'hFFFF_FFF0 : 32'h1234_5678;
                    if (c >= 2) predict("R4 stride path", lv, sv, 2'(c), 1'b1, 1'b1, lv + sv);
                    else        predict("R9 empty markov low conf", lv, sv, 2'(c), 1'b0, 1'b0, '0);
                end
            end
        end

        // R2 / R3 / R6 / R7 on PC 0x24
        a = 32'h1000;
        train(32'h24, a);
        lookup("R2 fresh entry", 32'h24, 1'b1, a, 32'd0, 2'd0);
        train(32'h24, a + 64);
        lookup("R3 stride replaced", 32'h24, 1'b1, a + 64, 32'd64, 2'd0);
        predict("R6 markov insert on break", a, '0, 2'd0, 1'b1, 1'b0, a + 64);
        train(32'h24, a + 128);
        lookup("R3 conf 1", 32'h24, 1'b1, a + 128, 32'd64, 2'd1);
        train(32'h24, a + 192);
        lookup("R3 conf 2", 32'h24, 1'b1, a + 192, 32'd64, 2'd2);
        train(32'h24, a + 256);
        lookup("R3 conf 3", 32'h24, 1'b1, a + 256, 32'd64, 2'd3);
        train(32'h24, a + 320);
        lookup("R3 conf saturates", 32'h24, 1'b1, a + 320, 32'd64, 2'd3);
        predict("R7 no insert for stride hit 64", a + 64, '0, 2'd0, 1'b0, 1'b0, '0);
        predict("R7 no insert for stride hit 128", a + 128, '0, 2'd0, 1'b0, 1'b0, '0);
        train(32'h24, a + 1020);
        lookup("R3 break resets conf", 32'h24, 1'b1, a + 1020, 32'd700, 2'd0);
        predict("R6 second insert", a + 320, '0, 2'd1, 1'b1, 1'b0, a + 1020);

        // R5 / R9 / R11: fill every Markov index from an evicting PC
        for (int i = 0; i < 16; i++) begin
            train(32'((i + 1) << 4), key_of(i));
            train(32'((i + 1) << 4), key_of(i) + 32'(delta_of(i)));
        end
        for (int i = 0; i < 16; i++) begin
            predict("R5 markov delta", key_of(i), '0, 2'(i % 2), 1'b1, 1'b0,
                    key_of(i) + 32'(delta_of(i)));
            predict("R9 tag mismatch", key_of(i) ^ 32'h400, '0, 2'd0, 1'b0, 1'b0, '0);
        end
        lookup("R11 evicted pc", 32'h10, 1'b0, '0, '0, 2'd0);
        lookup("R11 resident pc", 32'h100, 1'b1, key_of(15) + 32'(delta_of(15)),
               32'(delta_of(15)), 2'd0);

        // R8: out-of-range jumps leave index 3 untouched
        train(32'h110, key_of(3));
        train(32'h110, key_of(3) + 32'd32768);
        predict("R8 +32768 dropped", key_of(3), '0, 2'd0, 1'b1, 1'b0, key_of(3) + 32'(delta_of(3)));
        train(32'h110, key_of(3) - 32'd1);
        predict("R8 -32769 dropped", key_of(3), '0, 2'd0, 1'b1, 1'b0, key_of(3) + 32'(delta_of(3)));

        // R10: overwrite same key, then overwrite with another tag
        train(32'h120, key_of(5));
        train(32'h120, key_of(5) + 32'd8);
        predict("R10 same tag overwrite", key_of(5), '0, 2'd0, 1'b1, 1'b0, key_of(5) + 32'd8);
        train(32'h130, key_of(6) ^ 32'h400);
        train(32'h130, (key_of(6) ^ 32'h400) + 32'd4);
        predict("R10 old tag gone", key_of(6), '0, 2'd0, 1'b0, 1'b0, '0);
        predict("R10 new tag present", key_of(6) ^ 32'h400, '0, 2'd0, 1'b1, 1'b0,
                (key_of(6) ^ 32'h400) + 32'd4);

        finish_run();
    end
endmodule